// File: doc/BRIEF.md
# Hash Command Sequence Error Checker

This block sits between the software command register and the control path of a sponge-based hash and MAC engine. It follows the legal order of commands with a small state machine: a message starts, is fed, gets processed, is absorbed, and can then be squeezed repeatedly until software finishes. A command that does not fit the current state is dropped and reported. When a message starts, the block also checks the configuration. It checks the hash mode and security strength pair and, when the MAC function is on, the six-byte function-name prefix.

The error outputs and the filtered command are combinational. They are derived from the present command and the registered state, so the engine sees a dropped command as `CMD_NONE` in the same cycle it arrives. A fault escalation input forces a terminal state that suppresses all commands. A recovery input returns the machine to idle. Both inputs use 4-bit multi-bit encodings: `4'h6` means true and `4'h9` means false. The block has no data stream, so none of its pins carry valid/ready back-pressure. Every pin is a plain control or status level, sampled or produced every cycle.

Top module: `hash_cmd_guard`

## Requirements
- R1: During and right after reset, `state_o` is Idle (0), `err_valid_o` is 0, `err_code_o` is 0, and a `CMD_NONE` input passes through as 0. The reset is asynchronous and active low.
- R2: Command codes are None=0, Start=1, Process=2, ManualRun=3 and Done=4; codes 5 to 7 are illegal in every state. In Idle (0), only None and Start are legal. Start moves the state to MsgFeed (1) only when `app_active_i` is 0. When `app_active_i` is 1, Start is passed through without error and the state stays Idle.
- R3: In MsgFeed (1), only None and Process are legal, and Process moves the state to Processing (2).
- R4: In Processing (2), any command other than None is a sequence error. `absorbed_i` equal to exactly `4'h6` moves the state to Absorbed (3). Any other value leaves the state unchanged.
- R5: In Absorbed (3), None, ManualRun and Done are legal. ManualRun moves the state to Squeezing (4), and Done moves it to Idle.
- R6: In Squeezing (4), any command other than None is a sequence error, and `core_done_i` high returns the state to Absorbed.
- R7: On a sequence error, `cmd_o` is None (0) and the state keeps its value.
- R8: On the Idle-to-MsgFeed step, the mode and strength pair is checked. Mode codes are SHA3=0, SHAKE=2 and cSHAKE=3, and code 1 is never legal. Strength codes are 128=0, 224=1, 256=2, 384=3 and 512=4. SHA3 accepts 224, 256, 384 or 512, and both SHAKE variants accept 128 or 256. Any other pair raises error code 2. With `allow_unsup_i` at 0, the command is dropped and the state held. With `allow_unsup_i` at 1, the error is still reported but Start passes and the state moves on.
- R9: On that same step with `mac_en_i` high, a `mac_prefix_i` that differs from `MAC_NAME` raises error code 3. The command still passes and the state moves on.
- R10: `ent_unready_i` high together with any command other than None raises error code 4 and drops the command. With None, it raises nothing.
- R11: Error codes are sequence=1, mode/strength=2, prefix=3 and entropy=4, and 0 when there is no error. When several errors occur together, the lowest code is reported.
- R12: `escalate_i` at any value other than `4'h9` moves the state to TerminalError (5) on the next edge. This holds from every state and overrides a blocked command.
- R13: In TerminalError, `cmd_o` is None and no error is reported. `clear_i` equal to exactly `4'h6` returns the state to Idle from any state, unless escalation is active in the same cycle. Any other `clear_i` value has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Software command code |
| app_active_i | input | 1 | Application interface currently owns the engine |
| mode_i | input | 2 | Hash mode code |
| strength_i | input | 3 | Security strength code |
| mac_en_i | input | 1 | MAC function enabled |
| mac_prefix_i | input | 48 | Encoded function-name prefix |
| allow_unsup_i | input | 1 | Let an unsupported mode/strength pair proceed |
| ent_unready_i | input | 1 | Entropy not yet available |
| absorbed_i | input | 4 | Multi-bit absorb-complete status |
| core_done_i | input | 1 | Pulse: squeeze round finished |
| escalate_i | input | 4 | Multi-bit fault escalation |
| clear_i | input | 4 | Multi-bit clear-after-error request |
| cmd_o | output | 3 | Command forwarded to the engine, None when dropped |
| err_valid_o | output | 1 | An error is present this cycle |
| err_code_o | output | 3 | Highest-priority error code |
| state_o | output | 3 | Current sequence state |

## Verification
The bench targets overlapping faults. A Start that carries both a bad mode pair and missing entropy must report code 2 and not 4. An escalation that arrives with an illegal command must still reach the terminal state; a design that let the block-hold path win would stay in MsgFeed. It probes the multi-bit inputs near their true codes: an absorbed value of `4'hE` must not advance Processing, a clear of `4'h7` must not leave the terminal state, and an escalation of `4'h0` must still count as true. A design that used loose tests for absorbed or clear, or a strict test for escalation, would get one of these wrong. It also checks that an unsupported pair proceeds when allowed and that a bad prefix never blocks. A design that blocked on every configuration error would hold Idle in these cases.

// File: rtl/hash_cmd_pkg.sv
package hash_cmd_pkg;
  localparam int CMD_W  = 3;
  localparam int MODE_W = 2;
  localparam int STR_W  = 3;
  localparam int MB_W   = 4;
  localparam int ERR_W  = 3;
  localparam int ST_W   = 3;
  localparam int N_ERR  = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_NONE = 3'd0, CMD_START = 3'd1, CMD_PROCESS = 3'd2,
    CMD_RUN  = 3'd3, CMD_DONE  = 3'd4
  } cmd_e;

  typedef enum logic [MODE_W-1:0] {
    MODE_SHA3 = 2'd0, MODE_SHAKE = 2'd2, MODE_CSHAKE = 2'd3
  } mode_e;

  typedef enum logic [STR_W-1:0] {
    STR_128 = 3'd0, STR_224 = 3'd1, STR_256 = 3'd2,
    STR_384 = 3'd3, STR_512 = 3'd4
  } strength_e;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE = 3'd0, ST_MSG = 3'd1, ST_PROC = 3'd2,
    ST_ABS  = 3'd3, ST_SQZ = 3'd4, ST_TERM = 3'd5
  } seq_st_e;

  typedef enum logic [ERR_W-1:0] {
    ERR_NONE = 3'd0, ERR_SEQ = 3'd1, ERR_MODE = 3'd2,
    ERR_PREFIX = 3'd3, ERR_ENTROPY = 3'd4
  } err_e;

  localparam logic [MB_W-1:0] MB_TRUE  = 4'h6;
  localparam logic [MB_W-1:0] MB_FALSE = 4'h9;

  function automatic logic mb_strict(input logic [MB_W-1:0] v);
    return v == MB_TRUE;
  endfunction

  function automatic logic mb_loose(input logic [MB_W-1:0] v);
    return v != MB_FALSE;
  endfunction
endpackage

// File: rtl/hash_cmd_cfgchk.sv
module hash_cmd_cfgchk
  import hash_cmd_pkg::*;
#(
  parameter int              PREFIX_W = 48,
  parameter logic [PREFIX_W-1:0] MAC_NAME = 48'h434D_4B20_0100
) (
  input  logic                check_en,
  input  logic [MODE_W-1:0]   mode,
  input  logic [STR_W-1:0]    strength,
  input  logic                mac_en,
  input  logic [PREFIX_W-1:0] prefix,
  output logic                mode_err,
  output logic                prefix_err
);
  logic sha3_ok, shake_ok;

  always_comb begin
    sha3_ok  = (mode == MODE_SHA3) &&
               (strength inside {STR_224, STR_256, STR_384, STR_512});
    shake_ok = ((mode == MODE_SHAKE) || (mode == MODE_CSHAKE)) &&
               (strength inside {STR_128, STR_256});
  end

  assign mode_err   = check_en && !(sha3_ok || shake_ok);
  assign prefix_err = check_en && mac_en && (prefix != MAC_NAME);
endmodule

// File: rtl/hash_cmd_seq.sv
module hash_cmd_seq
  import hash_cmd_pkg::*;
(
  input  seq_st_e           state,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              app_active,
  input  logic              absorbed,
  input  logic              core_done,
  output logic              seq_err,
  output logic              quiet,
  output logic              start_msg,
  output seq_st_e           nxt
);
  always_comb begin
    seq_err = 1'b0;
    quiet   = 1'b0;
    nxt     = state;
    unique case (state)
      ST_IDLE: begin
        if (!(cmd inside {CMD_NONE, CMD_START})) seq_err = 1'b1;
        else if (cmd == CMD_START && !app_active) nxt = ST_MSG;
      end
      ST_MSG: begin
        if (!(cmd inside {CMD_NONE, CMD_PROCESS})) seq_err = 1'b1;
        else if (cmd == CMD_PROCESS) nxt = ST_PROC;
      end
      ST_PROC: begin
        if (cmd != CMD_NONE) seq_err = 1'b1;
        else if (absorbed) nxt = ST_ABS;
      end
      ST_ABS: begin
        if (!(cmd inside {CMD_NONE, CMD_RUN, CMD_DONE})) seq_err = 1'b1;
        else if (cmd == CMD_RUN)  nxt = ST_SQZ;
        else if (cmd == CMD_DONE) nxt = ST_IDLE;
      end
      ST_SQZ: begin
        if (cmd != CMD_NONE) seq_err = 1'b1;
        else if (core_done) nxt = ST_ABS;
      end
      default: begin
        quiet = 1'b1;
        nxt   = ST_TERM;
      end
    endcase
  end

  assign start_msg = (state == ST_IDLE) && (cmd == CMD_START) && !app_active;
endmodule

// File: rtl/hash_cmd_errsel.sv
module hash_cmd_errsel
  import hash_cmd_pkg::*;
#(
  parameter int N = N_ERR
) (
  input  logic [N-1:0]     err_vec,
  output logic             valid,
  output logic [ERR_W-1:0] code
);
  always_comb begin
    code = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (err_vec[i]) code = ERR_W'(i + 1);
    end
  end

  assign valid = |err_vec;
endmodule

// File: rtl/hash_cmd_guard.sv
module hash_cmd_guard
  import hash_cmd_pkg::*;
#(
  parameter int                  PREFIX_W = 48,
  parameter logic [PREFIX_W-1:0] MAC_NAME = 48'h434D_4B20_0100
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CMD_W-1:0]    cmd_i,
  input  logic                app_active_i,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic [STR_W-1:0]    strength_i,
  input  logic                mac_en_i,
  input  logic [PREFIX_W-1:0] mac_prefix_i,
  input  logic                allow_unsup_i,
  input  logic                ent_unready_i,
  input  logic [MB_W-1:0]     absorbed_i,
  input  logic                core_done_i,
  input  logic [MB_W-1:0]     escalate_i,
  input  logic [MB_W-1:0]     clear_i,
  output logic [CMD_W-1:0]    cmd_o,
  output logic                err_valid_o,
  output logic [ERR_W-1:0]    err_code_o,
  output logic [ST_W-1:0]     state_o
);
  seq_st_e state_q, state_d, fsm_nxt;
  logic seq_err, quiet, start_msg, mode_err, prefix_err, ent_err, block;

  hash_cmd_seq u_seq (
    .state      (state_q),
    .cmd        (cmd_i),
    .app_active (app_active_i),
    .absorbed   (mb_strict(absorbed_i)),
    .core_done  (core_done_i),
    .seq_err    (seq_err),
    .quiet      (quiet),
    .start_msg  (start_msg),
    .nxt        (fsm_nxt)
  );

  hash_cmd_cfgchk #(.PREFIX_W(PREFIX_W), .MAC_NAME(MAC_NAME)) u_cfg (
    .check_en   (start_msg),
    .mode       (mode_i),
    .strength   (strength_i),
    .mac_en     (mac_en_i),
    .prefix     (mac_prefix_i),
    .mode_err   (mode_err),
    .prefix_err (prefix_err)
  );

  assign ent_err = ent_unready_i && (cmd_i != CMD_NONE) && !quiet;

  hash_cmd_errsel #(.N(N_ERR)) u_sel (
    .err_vec ({ent_err, prefix_err, mode_err, seq_err}),
    .valid   (err_valid_o),
    .code    (err_code_o)
  );

  assign block = seq_err || ent_err || (mode_err && !allow_unsup_i);
  assign cmd_o = (block || quiet) ? CMD_NONE : cmd_i;

  always_comb begin
    if (mb_loose(escalate_i))     state_d = ST_TERM;
    else if (mb_strict(clear_i))  state_d = ST_IDLE;
    else if (block)               state_d = state_q;
    else                          state_d = fsm_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/hash_cmd_guard_chk.sv
module hash_cmd_guard_chk
  import hash_cmd_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [MB_W-1:0]  escalate_i,
  input logic [MB_W-1:0]  clear_i,
  input logic [CMD_W-1:0] cmd_o,
  input logic             err_valid_o,
  input logic [ERR_W-1:0] err_code_o,
  input logic [ST_W-1:0]  state_o
);
  logic esc, clr;
  assign esc = (escalate_i != MB_FALSE);
  assign clr = (clear_i == MB_TRUE);

  AST_ESC_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc |=> state_o == ST_TERM); // R12
  AST_CLEAR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!esc && clr) |=> state_o == ST_IDLE); // R13
  AST_SEQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_valid_o && err_code_o == ERR_SEQ && !esc && !clr) |=> $stable(state_o)); // R7
  AST_SEQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_valid_o && err_code_o == ERR_SEQ) |-> cmd_o == CMD_NONE); // R7
  AST_TERM_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_TERM) |-> (!err_valid_o && cmd_o == CMD_NONE)); // R13
  AST_IDLE_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_IDLE && !esc && !clr) |=> (state_o inside {ST_IDLE, ST_MSG})); // R2
  AST_PROC_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_PROC && !esc && !clr) |=> (state_o inside {ST_PROC, ST_ABS})); // R4
endmodule

bind hash_cmd_guard hash_cmd_guard_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .escalate_i  (escalate_i),
  .clear_i     (clear_i),
  .cmd_o       (cmd_o),
  .err_valid_o (err_valid_o),
  .err_code_o  (err_code_o),
  .state_o     (state_o)
);

// File: tb/test_hash_cmd_guard.sv
module test_hash_cmd_guard;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] GOOD_PFX = 48'h434D_4B20_0100;
  localparam logic [47:0] BAD_PFX  = GOOD_PFX ^ 48'h1;
  localparam logic [3:0] T = 4'h6, F = 4'h9;
  localparam logic [2:0] N = 3'd0, S = 3'd1, P = 3'd2, R = 3'd3, D = 3'd4;
  localparam logic [1:0] SHA = 2'd0, SHK = 2'd2, CSH = 2'd3;

  typedef struct packed {
    logic [3:0] req;  logic [2:0] cmd;  logic app;   logic [1:0] mode;
    logic [2:0] str;  logic mac;        logic pbad;  logic allow;
    logic ent;        logic [3:0] abs;  logic done;  logic [3:0] esc;
    logic [3:0] clr;  logic [2:0] ecmd; logic eerr;  logic [2:0] ecode;
    logic [2:0] est;
  } row_t;

  localparam int NROWS = 35;
  // req cmd app mode str mac pbad allow ent abs done esc clr | ecmd eerr ecode est
  localparam row_t ROWS [NROWS] = '{
    '{4'd2, N, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, F, F, N, 1'b0, 3'd0, 3'd0}, // R2 idle none
    '{4'd2, S, 1'b1, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, F, F, S, 1'b0, 3'd0, 3'd0}, // R2 app busy
    '{4'd8, S, 1'b0, SHK, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, F, F, N, 1'b1, 3'd2, 3'd0}, // R8 shake 224
    '{4'd11,S, 1'b0, SHK, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, F, 1'b0, F, F, N, 1'b1, 3'd2, 3'd0}, // R11 mode over entropy
    '{4'd7, P, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, F, F, N, 1'b1, 3'd1, 3'd0}, // R7 process in idle
    '{4'd11,P, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, F, 1'b0, F, F, N, 1'b1, 3'd1, 3'd0}, // R11 seq over entropy
    '{4'd10,N, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, F, 1'b0, F, F, N, 1'b0, 3'd0, 3'd0}, // R10 none ignores entropy
    '{4'd2, 3'd7,1'b0,SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, F, F, N, 1'b1, 3'd1, 3'd0}, // R2 illegal code 7
    '{4'd8, S, 1'b0, SHA, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, F, F, N, 1'b1, 3'd2, 3'd0}, // R8 sha3 128
    '{4'd8, S, 1'b0, 2'd1,3'd2, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, F, F, N, 1'b1, 3'd2, 3'd0}, // R8 mode code 1
    '{4'd9, S, 1'b0, SHA, 3'd4, 1'b1, 1'b1, 1'b0, 1'b0, F, 1'b0, F, F, S, 1'b1, 3'd3, 3'd1}, // R9 bad prefix passes
    '{4'd3, S, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, F, F, N, 1'b1, 3'd1, 3'd1}, // R3 start in msg
    '{4'd3, N, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, F, F, N, 1'b0, 3'd0, 3'd1}, // R3 none
    '{4'd10,P, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, F, 1'b0, F, F, N, 1'b1, 3'd4, 3'd1}, // R10 entropy blocks
    '{4'd3, P, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, F, F, P, 1'b0, 3'd0, 3'd2}, // R3 process
    '{4'd4, N, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'hE,1'b0,F, F, N, 1'b0, 3'd0, 3'd2}, // R4 not strict
    '{4'd4, D, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, T, 1'b0, F, F, N, 1'b1, 3'd1, 3'd2}, // R4 blocked holds
    '{4'd4, N, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, T, 1'b0, F, F, N, 1'b0, 3'd0, 3'd3}, // R4 absorbed
    '{4'd5, S, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, F, F, N, 1'b1, 3'd1, 3'd3}, // R5 start illegal
    '{4'd5, R, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, F, F, R, 1'b0, 3'd0, 3'd4}, // R5 manual run
    '{4'd6, R, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, F, F, N, 1'b1, 3'd1, 3'd4}, // R6 run in squeeze
    '{4'd6, N, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b1, F, F, N, 1'b0, 3'd0, 3'd3}, // R6 core done
    '{4'd5, D, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, F, F, D, 1'b0, 3'd0, 3'd0}, // R5 done
    '{4'd8, S, 1'b0, CSH, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0, F, 1'b0, F, F, S, 1'b1, 3'd2, 3'd1}, // R8 allowed proceeds
    '{4'd13,N, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, F, T, N, 1'b0, 3'd0, 3'd0}, // R13 clear from msg
    '{4'd8, S, 1'b0, SHK, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, F, F, S, 1'b0, 3'd0, 3'd1}, // R8 shake 128 legal
    '{4'd12,P, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, 4'h3, F, P, 1'b0, 3'd0, 3'd5}, // R12 escalate
    '{4'd13,S, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, F, F, N, 1'b0, 3'd0, 3'd5}, // R13 terminal quiet
    '{4'd13,N, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, F, T, N, 1'b0, 3'd0, 3'd0}, // R13 clear terminal
    '{4'd12,N, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, 4'h0, F, N, 1'b0, 3'd0, 3'd5}, // R12 loose 0
    '{4'd13,N, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, T, T, N, 1'b0, 3'd0, 3'd5}, // R13 escalation wins
    '{4'd13,N, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, F, 4'h7, N, 1'b0, 3'd0, 3'd5}, // R13 clear not strict
    '{4'd13,N, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, F, T, N, 1'b0, 3'd0, 3'd0}, // R13 clear
    '{4'd9, S, 1'b0, SHA, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, F, 1'b0, F, F, S, 1'b0, 3'd0, 3'd1}, // R9 good prefix
    '{4'd12,S, 1'b0, SHA, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, F, 1'b0, 4'h1, F, N, 1'b1, 3'd1, 3'd5}  // R12 over block
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cmd_i = '0, strength_i = '0;
  logic app_active_i = 1'b0, mac_en_i = 1'b0, allow_unsup_i = 1'b0;
  logic ent_unready_i = 1'b0, core_done_i = 1'b0;
  logic [1:0] mode_i = '0;
  logic [47:0] mac_prefix_i = GOOD_PFX;
  logic [3:0] absorbed_i = F, escalate_i = F, clear_i = F;
  logic [2:0] cmd_o, err_code_o, state_o;
  logic err_valid_o;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hash_cmd_guard i_hash_cmd_guard (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd_i), .app_active_i(app_active_i),
    .mode_i(mode_i), .strength_i(strength_i), .mac_en_i(mac_en_i),
    .mac_prefix_i(mac_prefix_i), .allow_unsup_i(allow_unsup_i),
    .ent_unready_i(ent_unready_i), .absorbed_i(absorbed_i),
    .core_done_i(core_done_i), .escalate_i(escalate_i), .clear_i(clear_i),
    .cmd_o(cmd_o), .err_valid_o(err_valid_o), .err_code_o(err_code_o),
    .state_o(state_o)
  );

  task automatic check(input string what, input int req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("reset state", 1, state_o, 0);         // R1
    check("reset err valid", 1, err_valid_o, 0); // R1
    check("reset err code", 1, err_code_o, 0);   // R1
    check("reset cmd", 1, cmd_o, 0);             // R1
    rst_n = 1'b1;

    for (int k = 0; k < NROWS; k++) begin
      @(negedge clk);
      cmd_i = ROWS[k].cmd;          app_active_i = ROWS[k].app;
      mode_i = ROWS[k].mode;        strength_i = ROWS[k].str;
      mac_en_i = ROWS[k].mac;       mac_prefix_i = ROWS[k].pbad ? BAD_PFX : GOOD_PFX;
      allow_unsup_i = ROWS[k].allow; ent_unready_i = ROWS[k].ent;
      absorbed_i = ROWS[k].abs;     core_done_i = ROWS[k].done;
      escalate_i = ROWS[k].esc;     clear_i = ROWS[k].clr;
      #1;
      check($sformatf("row %0d cmd_o", k), ROWS[k].req, cmd_o, ROWS[k].ecmd);
      check($sformatf("row %0d err valid", k), ROWS[k].req, err_valid_o, ROWS[k].eerr);
      check($sformatf("row %0d err code", k), ROWS[k].req, err_code_o, ROWS[k].ecode);
      @(posedge clk);
      #1;
      check($sformatf("row %0d next state", k), ROWS[k].req, state_o, ROWS[k].est);
    end

    // Directed: asynchronous reset out of the terminal state (R1)
    @(negedge clk);
    cmd_i = N; escalate_i = F; clear_i = F; ent_unready_i = 1'b0;
    rst_n = 1'b0;
    #1;
    check("async reset state", 1, state_o, 0);   // R1
    check("async reset err", 1, err_valid_o, 0); // R1
    @(negedge clk);
    rst_n = 1'b1;
    // Directed: app busy start keeps idle after reset (R2)
    cmd_i = S; app_active_i = 1'b1;
    @(posedge clk);
    #1;
    check("busy start holds idle", 2, state_o, 0); // R2

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule